// File: doc/BRIEF.md
# Timer-Counter and Watchdog with Shared Prescaler

This block holds an 8-bit up-counter and a watchdog timer. Both draw on one programmable power-of-two prescaler. A mode register decides which of the two the prescaler serves. The other one then counts its own source events with no division. The mode register also picks the division ratio and the counter's clock source. That source is either a one-cycle instruction-tick enable or transitions on an external pin. For the pin, the register also picks which edge counts. The external pin passes through a two-flop synchronizer and an edge detector before any counting logic sees it.

Software reaches the counter and the mode register through a plain single-cycle write strobe and a combinational read mux. When the counter wraps from all ones to zero it raises a sticky overflow flag, and only an explicit clear strobe lowers it. The watchdog counts a free-running tick input. When it wraps it emits a one-cycle timeout pulse and drops a "no timeout" status bit. A watchdog-clear strobe restarts the watchdog and raises that status bit again. No port carries streaming data, so every pin is a plain control or status signal and none uses a valid/ready handshake.

Top module: `tw_timer_wdt`

## Requirements
- R1: With the assignment bit (mode bit 3) at 0, the counter advances once per 2^(sel+1) source events, where sel is mode bits 2:0. Codes 0 to 7 give 1:2 to 1:256.
- R2: With the assignment bit at 1, the watchdog advances once per 2^sel watchdog ticks, giving 1:1 to 1:128. After a clear, the timeout fires on the 256·2^sel-th tick.
- R3: The side not holding the prescaler counts every one of its events directly. The counter counts each source event, and the watchdog times out on the 256th tick after a clear.
- R4: Source bit (mode bit 4) at 0 counts instruction ticks. At 1 it counts pin edges, and instruction ticks then have no effect on the counter.
- R5: Edge bit (mode bit 5) at 0 counts low-to-high pin transitions. At 1 it counts high-to-low transitions.
- R6: A counter step from 0xFF to 0x00 sets the overflow flag. The flag holds until the flag-clear strobe. If a set and a clear fall in the same cycle, the set wins.
- R7: A watchdog timeout gives a one-cycle timeout pulse and drives the status bit to 0. A watchdog clear zeroes the watchdog and drives the status bit to 1. A clear in the same cycle as a would-be timeout wins, so no pulse occurs.
- R8: A counter write loads the written value and clears the prescaler count. A watchdog clear also clears the prescaler count, but only when the assignment bit is 1.
- R9: After reset the counter reads 0, the mode register reads 0xFF, the overflow flag is 0 and the status bit is 1.
- R10: The mode register reads back bits 5:0 as written, and bits 7:6 always read 1. rd_sel 0 selects the counter and rd_sel 1 selects the mode register. wr_sel uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 mode |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 counter, 1 mode |
| rd_data | output | 8 | Read data (combinational) |
| cyc_tick | input | 1 | Instruction-cycle enable, one event per high cycle |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Free-running watchdog tick enable |
| wdt_clr | input | 1 | Watchdog clear strobe |
| flag_clr | input | 1 | Overflow flag clear strobe |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |
| to_stat | output | 1 | 1 = no timeout since last clear or reset |

## Verification
The bench sweeps every ratio code in both assignments and counts the events to the exact edge of each threshold. A ratio shifted one step the wrong way, or read as 2^sel for the counter, shows up as a count or timeout one event off by a factor of two. It leaves partial prescaler counts in place before counter writes and watchdog clears, so a design that does not clear the prescaler, or clears it on a watchdog clear while the prescaler belongs to the counter, shows a stray extra count. It drives set-versus-clear collisions on both the overflow flag and the watchdog, where a wrong priority loses a flag or emits a spurious timeout. It checks the pin path edge by edge and exposes an inverted edge select or leaking instruction ticks.

// File: rtl/tw_pkg.sv
package tw_pkg;
  parameter int SEL_W = 3;

  // Mode register fields, LSB first: sel[2:0], to_wdt[3], src_pin[4], edge_fall[5]
  typedef struct packed {
    logic             edge_fall;
    logic             src_pin;
    logic             to_wdt;
    logic [SEL_W-1:0] sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [STAGES:0] shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= {shreg_q[STAGES-1:0], pin};
  end

  logic cur, prev;
  assign cur  = shreg_q[STAGES-1];
  assign prev = shreg_q[STAGES];
  assign evt  = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int SEL_W = 3,
  localparam int PRE_W = 2 ** SEL_W,
  localparam int EXP_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             shift_up,
  output logic             evt_out
);
  logic [PRE_W-1:0] cnt_q;
  logic [EXP_W-1:0] expo;
  logic [PRE_W:0]   span;
  logic [PRE_W:0]   mask_full;
  logic [PRE_W-1:0] mask;

  assign expo      = {1'b0, sel} + {{SEL_W{1'b0}}, shift_up};
  assign span      = {{PRE_W{1'b0}}, 1'b1} << expo;
  assign mask_full = span - {{PRE_W{1'b0}}, 1'b1};
  assign mask      = mask_full[PRE_W-1:0];

  assign evt_out = evt_in && !clr && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (evt_in) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic timeout,
  output logic to_stat
);
  logic [WDT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = inc && (cnt_q == {WDT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
      to_stat <= 1'b1;
    end else if (clr) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
      to_stat <= 1'b1;
    end else begin
      if (inc) cnt_q <= cnt_q + 1'b1;
      timeout <= wrap;
      if (wrap) to_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_timer_wdt.sv
module tw_timer_wdt
  import tw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cyc_tick,
  input  logic              ext_pin,
  input  logic              wdt_tick,
  input  logic              wdt_clr,
  input  logic              flag_clr,
  output logic              ovf_flag,
  output logic              wdt_timeout,
  output logic              to_stat
);
  localparam int SPARE_W = DATA_W - MODE_W;
  localparam logic [DATA_W-1:0] SPARE_ONES = {{SPARE_W{1'b1}}, {MODE_W{1'b0}}};

  logic [DATA_W-1:0] mode_raw_q;
  logic [DATA_W-1:0] cnt_q;
  mode_t             mode;
  logic              cnt_wr, mode_wr;
  logic              pin_evt, src_evt, pre_in, pre_out, pre_clr;
  logic              cnt_inc, wdt_inc, ovf_set;

  assign mode    = mode_t'(mode_raw_q[MODE_W-1:0]);
  assign cnt_wr  = wr_en && !wr_sel;
  assign mode_wr = wr_en &&  wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_raw_q <= '1;
    else if (mode_wr) mode_raw_q <= wr_data | SPARE_ONES;
  end

  tw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .fall_sel (mode.edge_fall),
    .evt      (pin_evt)
  );

  assign src_evt = mode.src_pin ? pin_evt : cyc_tick;
  assign pre_in  = mode.to_wdt ? wdt_tick : src_evt;
  assign pre_clr = cnt_wr || (wdt_clr && mode.to_wdt);

  tw_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pre_clr),
    .evt_in   (pre_in),
    .sel      (mode.sel),
    .shift_up (!mode.to_wdt),
    .evt_out  (pre_out)
  );

  assign cnt_inc = mode.to_wdt ? src_evt : pre_out;
  assign wdt_inc = mode.to_wdt ? pre_out : wdt_tick;
  assign ovf_set = !cnt_wr && cnt_inc && (cnt_q == {DATA_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wr_data;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (ovf_set)  ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
  end

  tw_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wdt_clr),
    .inc     (wdt_inc),
    .timeout (wdt_timeout),
    .to_stat (to_stat)
  );

  assign rd_data = rd_sel ? mode_raw_q : cnt_q;
endmodule

// File: rtl/tw_timer_wdt_chk.sv
module tw_timer_wdt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic         wdt_clr,
  input logic         flag_clr,
  input logic         ovf_flag,
  input logic         wdt_timeout,
  input logic         to_stat,
  input logic [W-1:0] cnt
);
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(cnt) == '1 && !$past(wr_en && !wr_sel)) |-> ovf_flag); // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R6
  AST_TIMEOUT_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> !to_stat); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> (to_stat && !wdt_timeout)); // R7
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout); // R7
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> cnt == $past(wr_data)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R1
endmodule

bind tw_timer_wdt tw_timer_wdt_chk #(.W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .wdt_clr     (wdt_clr),
  .flag_clr    (flag_clr),
  .ovf_flag    (ovf_flag),
  .wdt_timeout (wdt_timeout),
  .to_stat     (to_stat),
  .cnt         (cnt_q)
);

// File: tb/tw_timer_wdt_tb.sv
module tw_timer_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       cyc_tick = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0;
  logic       wdt_clr = 1'b0, flag_clr = 1'b0;
  logic       ovf_flag, wdt_timeout, to_stat;
  int         total = 0, fails = 0;

  always #2 clk = ~clk;

  tw_timer_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout), .to_stat(to_stat)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic cyc(input int n);
    if (n > 0) begin
      @(negedge clk); cyc_tick = 1'b1;
      repeat (n) @(negedge clk);
      cyc_tick = 1'b0;
    end
  endtask

  task automatic wtick(input int n);
    if (n > 0) begin
      @(negedge clk); wdt_tick = 1'b1;
      repeat (n) @(negedge clk);
      wdt_tick = 1'b0;
    end
  endtask

  task automatic wclr();
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); ext_pin = v;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(1'b0, v); check("R9 counter", v, 0);
    rd(1'b1, v); check("R9 mode", v, 8'hFF);
    check("R9 flag", ovf_flag, 0);
    check("R9 status", to_stat, 1);

    // R10 read-back with spare bits forced high
    wr(1'b1, 8'h15); rd(1'b1, v); check("R10 mode readback", v, 8'hD5);

    // R1 counter ratio sweep
    for (int s = 0; s < 8; s++) begin
      int r;
      r = 1 << (s + 1);
      wr(1'b1, 8'(s)); wr(1'b0, 8'h00);
      cyc(3 * r - 1); rd(1'b0, v); check($sformatf("R1 sel %0d below", s), v, 2);
      cyc(1);         rd(1'b0, v); check($sformatf("R1 sel %0d edge", s), v, 3);
    end

    // R8 counter write clears prescaler; watchdog clear does not when unassigned
    wr(1'b1, 8'h01); wr(1'b0, 8'h00);
    cyc(3); wr(1'b0, 8'h00); cyc(3); rd(1'b0, v); check("R8 write clears prescaler", v, 0);
    cyc(1); rd(1'b0, v); check("R8 after full ratio", v, 1);
    wr(1'b0, 8'h00); cyc(3); wclr(); cyc(1); rd(1'b0, v); check("R8 clear ignored when unassigned", v, 1);

    // R3 direct counting and R6 overflow
    wr(1'b1, 8'h0F); wr(1'b0, 8'h00);
    cyc(37); rd(1'b0, v); check("R3 direct counter", v, 37);
    wr(1'b0, 8'hFE); cyc(1); check("R6 no flag at FF", ovf_flag, 0);
    cyc(1); rd(1'b0, v); check("R6 wrap value", v, 0); check("R6 flag set", ovf_flag, 1);
    cyc(3); check("R6 flag sticky", ovf_flag, 1);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R6 flag cleared", ovf_flag, 0);
    wr(1'b0, 8'hFF);
    @(negedge clk); cyc_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk); cyc_tick = 1'b0; flag_clr = 1'b0;
    check("R6 set beats clear", ovf_flag, 1);

    // R4 pin source, instruction ticks ignored
    wr(1'b1, 8'h18); wr(1'b0, 8'h00);
    cyc(10); rd(1'b0, v); check("R4 ticks ignored", v, 0);
    for (int i = 0; i < 5; i++) begin pin_set(1'b1); pin_set(1'b0); end
    rd(1'b0, v); check("R4 pin edges", v, 5);
    // R5 edge polarity
    pin_set(1'b1); rd(1'b0, v); check("R5 rising counted", v, 6);
    pin_set(1'b0); rd(1'b0, v); check("R5 falling not counted", v, 6);
    wr(1'b1, 8'h38); wr(1'b0, 8'h00);
    pin_set(1'b1); rd(1'b0, v); check("R5 rising ignored", v, 0);
    pin_set(1'b0); rd(1'b0, v); check("R5 falling counted", v, 1);

    // R2 watchdog ratio sweep
    for (int s = 0; s < 8; s++) begin
      int r;
      r = 1 << s;
      wr(1'b1, 8'(8'h08 | s)); wclr();
      check($sformatf("R7 status after clear sel %0d", s), to_stat, 1);
      wtick(256 * r - 1);
      check($sformatf("R2 sel %0d no timeout", s), wdt_timeout + 2 * to_stat, 2);
      wtick(1);
      check($sformatf("R2 sel %0d timeout", s), wdt_timeout + 2 * to_stat, 1);
      @(negedge clk); check($sformatf("R7 pulse width sel %0d", s), wdt_timeout, 0);
    end

    // R2/R8: watchdog clear resets assigned prescaler
    wr(1'b1, 8'h09); wclr();
    wtick(1); wclr(); wtick(256 * 2 - 1);
    check("R8 clear resets prescaler", wdt_timeout + 2 * to_stat, 2);
    wtick(1); check("R8 timeout after clear", wdt_timeout, 1);

    // R3 watchdog direct, R7 clear beats timeout
    wr(1'b1, 8'h00); wclr();
    wtick(255); check("R3 wdt no timeout", to_stat, 1);
    wtick(1); check("R3 wdt timeout", wdt_timeout + 2 * to_stat, 1);
    wtick(255);
    @(negedge clk); wdt_tick = 1'b1; wdt_clr = 1'b1;
    @(negedge clk); wdt_tick = 1'b0; wdt_clr = 1'b0;
    check("R7 clear beats timeout", wdt_timeout + 2 * to_stat, 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule